// File: doc/BRIEF.md
# Dual-Clock Up/Down Counter

The block is a four-bit counter with two count lines, one for counting up and one for counting down. Each line counts on its rising edge, but only while the other line rests high. A master clear and a parallel jam-load path with an active-low enable take priority over counting. A parameter chooses between decade counting (0 to 9) and plain binary counting (0 to 15).

Two active-low outputs, carry and borrow, stay high at rest. Carry drops while the count sits at its top value and the up line is low. Borrow drops while the count is zero and the down line is low. Each output therefore has the shape of a count line, and it can drive the up or down line of a following stage directly. A chain of stages then forms a multi-digit counter with no glue logic.

All of the control and data inputs are treated as asynchronous levels. A free-running system clock passes them through a two-stage synchronizer, and a count happens when a synchronized count line goes from 0 to 1. The system reset `rst_n` asserts asynchronously. It must be released synchronously to `clk` by the surrounding logic.

Top module: `updown_dual_clk_counter`

## Requirements
- R1: While `clear` is high the count is 0, whatever either count line does.
- R2: While `load_n` is low and `clear` is low, the count equals `jam`. When both are active, `clear` wins and the count is 0.
- R3: A rising edge on `up_clk` while `dn_clk` is high adds one to the count.
- R4: A rising edge on `dn_clk` while `up_clk` is high subtracts one from the count.
- R5: A rising edge on one count line while the other line is low leaves the count unchanged.
- R6: If both count lines rise in the same system-clock cycle, the count is unchanged.
- R7: With DECADE=1 the top value is 9. Counting up from 9 gives 0, and counting down from 0 gives 9.
- R8: With DECADE=0 the top value is 15. Counting up from 15 gives 0, counting down from 0 gives 15, and up from 9 gives 10.
- R9: `carry_n` is low exactly when the count equals the top value and the synchronized `up_clk` is low. Otherwise it is high.
- R10: `borrow_n` is low exactly when the count is 0 and the synchronized `dn_clk` is low. Otherwise it is high.
- R11: While `clear` is high or `load_n` is low, `carry_n` and `borrow_n` are both high.
- R12: With DECADE=1, a jam-loaded value above 9 is held as loaded. Counting up from it gives 0, and counting down from it gives the value minus one.
- R13: A second stage whose `up_clk` is driven by the first stage's `carry_n`, and whose `dn_clk` is driven by the first stage's `borrow_n`, forms a correct two-digit up/down count.
- R14: After reset the count is 0 and both `carry_n` and `borrow_n` are high. An input change reaches the count on the third `clk` rising edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all other inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| up_clk | input | 1 | Count-up line, active on its rising edge |
| dn_clk | input | 1 | Count-down line, active on its rising edge |
| load_n | input | 1 | Active-low jam-load enable |
| clear | input | 1 | Active-high master clear |
| jam | input | CNT_W | Parallel load value |
| count | output | CNT_W | Current count |
| carry_n | output | 1 | Active-low carry, shaped like the up line |
| borrow_n | output | 1 | Active-low borrow, shaped like the down line |

## Verification
Two functions can land in the same system-clock cycle: an up step and a down step, when both count lines rise together. The bench provokes this by taking both lines low and then releasing them on the same falling edge of `clk`, so the two synchronizers report their rising edges in the same cycle. The result is judged at the port: the count must read the same value after the event as before it. A second collision, between clear and jam-load, is provoked by asserting both at once. That case is judged by a zero count that turns into the jam value once clear is released.

// File: rtl/udc_pkg.sv
package udc_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_INC  = 2'd1,
    ACT_DEC  = 2'd2
  } udc_act_e;

  function automatic int unsigned udc_top_value(input bit decade, input int unsigned width);
    return decade ? 32'd9 : ((32'd1 << width) - 32'd1);
  endfunction

endpackage

// File: rtl/udc_sync.sv
module udc_sync #(
  parameter int unsigned W       = 8,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/udc_edge.sv
module udc_edge #(
  parameter int unsigned W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

endmodule

// File: rtl/udc_core.sv
module udc_core
  import udc_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter logic [CNT_W-1:0] MAX_VAL = 4'd9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load_n,
  input  logic [CNT_W-1:0] jam,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  input  logic             up_rise,
  input  logic             dn_rise,
  output logic [CNT_W-1:0] count
);

  udc_act_e         act;
  logic [CNT_W-1:0] count_d;
  logic [CNT_W-1:0] count_q;
  logic             count_en;

  // choose the step: a rise only counts while the opposite line rests high
  always_comb begin
    act = ACT_HOLD;
    if (up_rise && !dn_rise && dn_lvl)      act = ACT_INC;
    else if (dn_rise && !up_rise && up_lvl) act = ACT_DEC;
  end

  always_comb begin
    count_d = count_q;
    if (clr)          count_d = '0;
    else if (!load_n) count_d = jam;
    else begin
      unique case (act)
        ACT_INC:  count_d = (count_q >= MAX_VAL) ? '0 : count_q + 1'b1;
        ACT_DEC:  count_d = (count_q == '0) ? MAX_VAL : count_q - 1'b1;
        default:  count_d = count_q;
      endcase
    end
  end

  assign count_en = clr || !load_n || (act != ACT_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count = count_q;

endmodule

// File: rtl/udc_flags.sv
module udc_flags #(
  parameter int unsigned CNT_W = 4,
  parameter logic [CNT_W-1:0] MAX_VAL = 4'd9
) (
  input  logic [CNT_W-1:0] count,
  input  logic             clr,
  input  logic             load_n,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);

  logic override;
  logic at_top;
  logic at_zero;

  assign override = clr || !load_n;
  assign at_top   = (count == MAX_VAL);
  assign at_zero  = (count == '0);

  always_comb begin
    carry_n  = 1'b1;
    borrow_n = 1'b1;
    if (!override) begin
      carry_n  = !(at_top && !up_lvl);
      borrow_n = !(at_zero && !dn_lvl);
    end
  end

endmodule

// File: rtl/updown_dual_clk_counter.sv
module updown_dual_clk_counter
  import udc_pkg::*;
#(
  parameter bit          DECADE      = 1'b1,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_clk,
  input  logic             dn_clk,
  input  logic             load_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] jam,
  output logic [CNT_W-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);

  localparam int unsigned TOP_INT = udc_top_value(DECADE, CNT_W);
  localparam logic [CNT_W-1:0] MAX_VAL = TOP_INT[CNT_W-1:0];
  localparam int unsigned SW = CNT_W + 4;
  // bundle layout: {clear, load_n, dn, up, jam}; idle levels as reset values
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, 1'b1, {CNT_W{1'b0}}};

  logic [SW-1:0]    raw_bus;
  logic [SW-1:0]    sync_bus;
  logic             clr_s;
  logic             load_n_s;
  logic             up_s;
  logic             dn_s;
  logic [CNT_W-1:0] jam_s;
  logic [1:0]       rise_bus;
  logic             up_rise;
  logic             dn_rise;
  logic [CNT_W-1:0] count_q;

  assign raw_bus = {clear, load_n, dn_clk, up_clk, jam};

  udc_sync #(
    .W      (SW),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_bus),
    .q    (sync_bus)
  );

  assign {clr_s, load_n_s, dn_s, up_s, jam_s} = sync_bus;

  udc_edge #(
    .W      (2),
    .RST_VAL(2'b11)
  ) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({dn_s, up_s}),
    .rise (rise_bus)
  );

  assign {dn_rise, up_rise} = rise_bus;

  udc_core #(
    .CNT_W  (CNT_W),
    .MAX_VAL(MAX_VAL)
  ) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_s),
    .load_n (load_n_s),
    .jam    (jam_s),
    .up_lvl (up_s),
    .dn_lvl (dn_s),
    .up_rise(up_rise),
    .dn_rise(dn_rise),
    .count  (count_q)
  );

  udc_flags #(
    .CNT_W  (CNT_W),
    .MAX_VAL(MAX_VAL)
  ) u_flags (
    .count   (count_q),
    .clr     (clr_s),
    .load_n  (load_n_s),
    .up_lvl  (up_s),
    .dn_lvl  (dn_s),
    .carry_n (carry_n),
    .borrow_n(borrow_n)
  );

  assign count = count_q;

endmodule

// File: rtl/udc_checker.sv
module udc_checker #(
  parameter int unsigned CNT_W = 4,
  parameter logic [CNT_W-1:0] MAX_VAL = 4'd9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_s,
  input logic             load_n_s,
  input logic             up_s,
  input logic             dn_s,
  input logic             up_rise,
  input logic             dn_rise,
  input logic [CNT_W-1:0] jam_s,
  input logic [CNT_W-1:0] count,
  input logic             carry_n,
  input logic             borrow_n
);

  function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] v);
    return (v >= MAX_VAL) ? '0 : v + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] step_dn(input logic [CNT_W-1:0] v);
    return (v == '0) ? MAX_VAL : v - 1'b1;
  endfunction

  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> (count == '0));

  assert_load_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && !load_n_s) |=> (count == $past(jam_s)));

  assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && load_n_s && up_rise && !dn_rise && dn_s) |=> (count == step_up($past(count))));

  assert_dn_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && load_n_s && dn_rise && !up_rise && up_s) |=> (count == step_dn($past(count))));

  assert_no_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && load_n_s && !up_rise && !dn_rise) |=> $stable(count));

  assert_both_edges_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && load_n_s && up_rise && dn_rise) |=> $stable(count));

  assert_carry_rest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((count != MAX_VAL) || up_s) |-> carry_n);

  assert_borrow_rest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((count != '0) || dn_s) |-> borrow_n);

  assert_flags_forced_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s || !load_n_s) |-> (carry_n && borrow_n));

endmodule

bind updown_dual_clk_counter udc_checker #(
  .CNT_W  (CNT_W),
  .MAX_VAL(MAX_VAL)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr_s   (clr_s),
  .load_n_s(load_n_s),
  .up_s    (up_s),
  .dn_s    (dn_s),
  .up_rise (up_rise),
  .dn_rise (dn_rise),
  .jam_s   (jam_s),
  .count   (count),
  .carry_n (carry_n),
  .borrow_n(borrow_n)
);

// File: tb/updown_dual_clk_counter_tb.sv
module updown_dual_clk_counter_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // decade device under test
  logic       up = 1'b1, dn = 1'b1, ld_n = 1'b1, clr = 1'b0;
  logic [3:0] jam = 4'd0;
  logic [3:0] cnt;
  logic       cy_n, bw_n;

  updown_dual_clk_counter #(.DECADE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .up_clk(up), .dn_clk(dn), .load_n(ld_n),
    .clear(clr), .jam(jam), .count(cnt), .carry_n(cy_n), .borrow_n(bw_n));

  // binary instance
  logic       b_up = 1'b1, b_dn = 1'b1, b_ld_n = 1'b1;
  logic [3:0] b_jam = 4'd0;
  logic [3:0] b_cnt;
  logic       b_cy_n, b_bw_n;

  updown_dual_clk_counter #(.DECADE(1'b0)) u_bin (
    .clk(clk), .rst_n(rst_n), .up_clk(b_up), .dn_clk(b_dn), .load_n(b_ld_n),
    .clear(1'b0), .jam(b_jam), .count(b_cnt), .carry_n(b_cy_n), .borrow_n(b_bw_n));

  // two-digit cascade
  logic       c_up = 1'b1, c_dn = 1'b1, c_clr = 1'b0;
  logic [3:0] lo_cnt, hi_cnt;
  logic       lo_cy_n, lo_bw_n, hi_cy_n, hi_bw_n;

  updown_dual_clk_counter #(.DECADE(1'b1)) u_lo (
    .clk(clk), .rst_n(rst_n), .up_clk(c_up), .dn_clk(c_dn), .load_n(1'b1),
    .clear(c_clr), .jam(4'd0), .count(lo_cnt), .carry_n(lo_cy_n), .borrow_n(lo_bw_n));

  updown_dual_clk_counter #(.DECADE(1'b1)) u_hi (
    .clk(clk), .rst_n(rst_n), .up_clk(lo_cy_n), .dn_clk(lo_bw_n), .load_n(1'b1),
    .clear(c_clr), .jam(4'd0), .count(hi_cnt), .carry_n(hi_cy_n), .borrow_n(hi_bw_n));

  // vector: {op[15:14], arg[13:10], exp[9:6], req[5:0]}; op 0 up, 1 down, 2 load, 3 clear
  localparam int NV = 18;
  localparam logic [15:0] VEC [NV] = '{
    {2'd3, 4'd0,  4'd0,  6'd1},   // R1 clear
    {2'd0, 4'd0,  4'd1,  6'd3},   // R3
    {2'd0, 4'd0,  4'd2,  6'd3},   // R3
    {2'd1, 4'd0,  4'd1,  6'd4},   // R4
    {2'd2, 4'd7,  4'd7,  6'd2},   // R2 load
    {2'd0, 4'd0,  4'd8,  6'd3},   // R3
    {2'd0, 4'd0,  4'd9,  6'd3},   // R3
    {2'd0, 4'd0,  4'd0,  6'd7},   // R7 9 -> 0
    {2'd1, 4'd0,  4'd9,  6'd7},   // R7 0 -> 9
    {2'd1, 4'd0,  4'd8,  6'd4},   // R4
    {2'd2, 4'd0,  4'd0,  6'd2},   // R2
    {2'd1, 4'd0,  4'd9,  6'd7},   // R7
    {2'd2, 4'd12, 4'd12, 6'd12},  // R12 load above 9
    {2'd0, 4'd0,  4'd0,  6'd12},  // R12 up -> 0
    {2'd2, 4'd14, 4'd14, 6'd12},  // R12
    {2'd1, 4'd0,  4'd13, 6'd12},  // R12 down -> value-1
    {2'd1, 4'd0,  4'd12, 6'd12},  // R12
    {2'd3, 4'd0,  4'd0,  6'd1}    // R1
  };

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_up();
    up = 1'b0; waitc(5); up = 1'b1; waitc(5);
  endtask

  task automatic pulse_dn();
    dn = 1'b0; waitc(5); dn = 1'b1; waitc(5);
  endtask

  task automatic do_load(input logic [3:0] v);
    jam = v; ld_n = 1'b0; waitc(5); ld_n = 1'b1; waitc(5);
  endtask

  task automatic c_pulse_up();
    c_up = 1'b0; waitc(5); c_up = 1'b1; waitc(8);
  endtask

  task automatic c_pulse_dn();
    c_dn = 1'b0; waitc(5); c_dn = 1'b1; waitc(8);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    waitc(3);
    rst_n = 1'b1;
    waitc(2);
    // R14 reset state
    check("R14 count", cnt, 0);
    check("R14 carry", cy_n, 1);
    check("R14 borrow", bw_n, 1);

    // R14 latency: load applied at a falling edge appears after the third rising edge
    jam = 4'd6; ld_n = 1'b0;
    waitc(2);
    check("R14 before", cnt, 0);
    waitc(1);
    check("R14 after", cnt, 6);
    ld_n = 1'b1; waitc(5);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][15:14];
      case (op)
        2'd0: pulse_up();
        2'd1: pulse_dn();
        2'd2: do_load(VEC[i][13:10]);
        default: begin clr = 1'b1; waitc(5); clr = 1'b0; waitc(5); end
      endcase
      check($sformatf("R%0d vec%0d", VEC[i][5:0], i), cnt, VEC[i][9:6]);
    end

    // R5 gating
    do_load(4'd5);
    dn = 1'b0; waitc(5);
    up = 1'b0; waitc(5); up = 1'b1; waitc(5);
    check("R5 up edge with down low", cnt, 5);
    dn = 1'b1; waitc(5);
    check("R4 down edge with up high", cnt, 4);
    up = 1'b0; waitc(5); dn = 1'b0; waitc(5); dn = 1'b1; waitc(5);
    check("R5 down edge with up low", cnt, 4);
    up = 1'b1; waitc(5);
    check("R3 up edge with down high", cnt, 5);

    // R6 both edges together
    up = 1'b0; dn = 1'b0; waitc(5);
    up = 1'b1; dn = 1'b1; waitc(5);
    check("R6 simultaneous edges", cnt, 5);

    // R9 carry
    do_load(4'd9);
    check("R9 carry idle", cy_n, 1);
    up = 1'b0; waitc(5);
    check("R9 carry low", cy_n, 0);
    check("R10 borrow idle", bw_n, 1);
    up = 1'b1; waitc(5);
    check("R9 carry back high", cy_n, 1);
    check("R7 wrap via carry", cnt, 0);

    // R10 borrow
    dn = 1'b0; waitc(5);
    check("R10 borrow low", bw_n, 0);
    dn = 1'b1; waitc(5);
    check("R10 borrow high", bw_n, 1);
    check("R7 wrap via borrow", cnt, 9);

    // R11 forced flags during load and clear
    jam = 4'd9; ld_n = 1'b0; up = 1'b0; waitc(5);
    check("R11 carry during load", cy_n, 1);
    ld_n = 1'b1; waitc(5);
    check("R9 carry after load", cy_n, 0);
    up = 1'b1; waitc(5);
    check("R3 wrap", cnt, 0);
    clr = 1'b1; dn = 1'b0; waitc(5);
    check("R11 borrow during clear", bw_n, 1);
    pulse_up();
    check("R1 count held by clear", cnt, 0);
    clr = 1'b0; waitc(5);
    check("R10 borrow after clear", bw_n, 0);
    dn = 1'b1; waitc(5);
    check("R4 wrap", cnt, 9);

    // R2 priority
    clr = 1'b1; jam = 4'd5; ld_n = 1'b0; waitc(5);
    check("R2 clear over load", cnt, 0);
    clr = 1'b0; waitc(5);
    check("R2 load after clear", cnt, 5);
    ld_n = 1'b1; waitc(5);

    // R8 binary
    b_jam = 4'd15; b_ld_n = 1'b0; waitc(5); b_ld_n = 1'b1; waitc(5);
    b_up = 1'b0; waitc(5);
    check("R8 carry at 15", b_cy_n, 0);
    b_up = 1'b1; waitc(5);
    check("R8 15 -> 0", b_cnt, 0);
    b_dn = 1'b0; waitc(5); b_dn = 1'b1; waitc(5);
    check("R8 0 -> 15", b_cnt, 15);
    b_jam = 4'd9; b_ld_n = 1'b0; waitc(5); b_ld_n = 1'b1; waitc(5);
    b_up = 1'b0; waitc(5); b_up = 1'b1; waitc(5);
    check("R8 9 -> 10", b_cnt, 10);

    // R13 cascade
    c_clr = 1'b1; waitc(5); c_clr = 1'b0; waitc(5);
    for (int k = 0; k < 12; k++) c_pulse_up();
    check("R13 low digit up", lo_cnt, 2);
    check("R13 high digit up", hi_cnt, 1);
    for (int k = 0; k < 3; k++) c_pulse_dn();
    check("R13 low digit down", lo_cnt, 9);
    check("R13 high digit down", hi_cnt, 0);
    c_pulse_dn();
    check("R13 low digit wrap", lo_cnt, 8);
    c_pulse_up(); c_pulse_up();
    check("R13 low after carry", lo_cnt, 0);
    check("R13 high after carry", hi_cnt, 1);

    finish_run();
  end

endmodule